// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block is a small translation cache that sits in front of a page-table walker. It stores recently used mappings from virtual page numbers to physical page numbers. A lookup presents a virtual page number and gets back a hit flag and the physical page number combinationally, in the same cycle. On a miss the surrounding logic translates through the full page table. It then writes the result back through the fill port.

The storage has 16 entries, arranged as 4 sets of 4 ways. The two low bits of the virtual page number select a set. The remaining six bits form the tag that is compared against every way of that set. Each way holds a tag, a physical page number and a valid bit. A fill is placed in the following order:
- A way that already holds the same virtual page number is rewritten in place.
- Otherwise the lowest-numbered invalid way is used.
- Otherwise the way named by a round-robin pointer kept for each set is replaced.

A flush invalidates every entry in one cycle, as on a context switch.

Top module: `tlb_top`

## Requirements
- R1: The set index is lookupVpn bits [1:0] and the tag is lookupVpn bits [7:2]. Two page numbers that share a tag but differ in set index never hit on each other's entry.
- R2: lookupHit is high in the same cycle exactly when some way of the indexed set is valid and holds the presented tag. lookupPpn then carries that way's page number. On a miss lookupPpn is zero.
- R3: After reset every entry is invalid, so every lookup misses.
- R4: A fill whose page number is absent from its set writes into the lowest-numbered invalid way of that set, if any way is invalid.
- R5: A fill into a set whose four ways are all valid, with no matching entry, replaces the way named by that set's round-robin pointer. The pointer starts at way 0 and advances by one, wrapping from 3 to 0, only on such a replacement.
- R6: A fill whose page number is already present rewrites that way's physical page number. It creates no duplicate and evicts nothing.
- R7: A flush invalidates all entries and resets all round-robin pointers at the next clock edge. A fill presented in the same cycle as a flush is dropped.
- R8: A fill takes effect at the clock edge. A lookup of the same page number misses, or returns the old mapping, in the fill cycle and returns the new mapping from the next cycle on.
- R9: With set 3 holding tag 0x03 mapped to page 0x0D, virtual address 0x03D4 (page 0x0F) hits and returns 0x0D. Virtual address 0x028F (page 0x0A, set 2, tag 0x02) misses while set 2 holds no valid tag 0x02. Virtual address 0x0040 (page 0x01) misses while absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupVpn | input | 8 | Virtual page number to translate |
| lookupHit | output | 1 | High when the translation is present |
| lookupPpn | output | 6 | Physical page number on a hit, zero on a miss |
| fillEn | input | 1 | Write the fill translation at this clock edge |
| fillVpn | input | 8 | Virtual page number of the translation being written |
| fillPpn | input | 6 | Physical page number of the translation being written |
| flush | input | 1 | Invalidate all entries at this clock edge |

## Verification
A wrong internal state shows up at the lookup outputs the first time that page number is presented again. A stale valid bit gives a hit that should be a miss, a bad tag or page number gives a wrong lookupPpn, and a misplaced round-robin pointer evicts the wrong victim. The bench compares every cycle against a behavioural model. It also looks up the old page numbers after each eviction, so a wrong victim is seen within a few cycles of the fill that chose it. Flush and duplicate refills are mixed into random traffic, which runs over a narrow page range to force many conflicts.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TLB_SETS = 4;
  localparam int TLB_WAYS = 4;
  localparam int SET_BITS = $clog2(TLB_SETS);
  localparam int WAY_BITS = $clog2(TLB_WAYS);

  // strobes from control to the entry store
  typedef struct packed {
    logic                clrAll;
    logic                wrEn;
    logic [TLB_WAYS-1:0] wrWay;
  } tlb_strobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                fillEn,
  input  logic                flush,
  input  logic [SET_BITS-1:0] fillSet,
  input  logic [TLB_WAYS-1:0] fillMatch,
  input  logic [TLB_WAYS-1:0] fillValid,
  output tlb_strobe_t         strb
);
  logic [WAY_BITS-1:0] rrPtr [TLB_SETS];
  logic [WAY_BITS-1:0] freeWay;
  logic                replaceEv;

  always_comb begin
    freeWay = '0;
    for (int w = TLB_WAYS - 1; w >= 0; w--) begin
      if (!fillValid[w]) freeWay = WAY_BITS'(w);
    end
  end

  always_comb begin
    strb      = '0;
    replaceEv = 1'b0;
    if (flush) begin
      strb.clrAll = 1'b1;
    end else if (fillEn) begin
      strb.wrEn = 1'b1;
      if (|fillMatch) begin
        strb.wrWay = fillMatch;
      end else if (!(&fillValid)) begin
        strb.wrWay = TLB_WAYS'(1) << freeWay;
      end else begin
        strb.wrWay = TLB_WAYS'(1) << rrPtr[fillSet];
        replaceEv  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < TLB_SETS; s++) rrPtr[s] <= '0;
    end else if (flush) begin
      for (int s = 0; s < TLB_SETS; s++) rrPtr[s] <= '0;
    end else if (replaceEv) begin
      rrPtr[fillSet] <= rrPtr[fillSet] + 1'b1;
    end
  end

  // R4: every write targets exactly one way
  assert_write_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> $onehot(strb.wrWay));

  // R7: a flush cycle never writes
  assert_flush_drops_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !strb.wrEn);

  // R5: a replacement only occurs into a full set
  assert_replace_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !(|(strb.wrWay & fillMatch)) && |(strb.wrWay & fillValid)) |-> (&fillValid));
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  tlb_strobe_t         strb,
  input  logic [VPN_W-1:0]    fillVpn,
  input  logic [PPN_W-1:0]    fillPpn,
  input  logic [VPN_W-1:0]    lookupVpn,
  output logic                lookupHit,
  output logic [PPN_W-1:0]    lookupPpn,
  output logic [TLB_WAYS-1:0] fillMatch,
  output logic [TLB_WAYS-1:0] fillValid
);
  localparam int TAG_W = VPN_W - SET_BITS;

  logic [TAG_W-1:0]    tagMem   [TLB_SETS][TLB_WAYS];
  logic [PPN_W-1:0]    ppnMem   [TLB_SETS][TLB_WAYS];
  logic [TLB_WAYS-1:0] validMem [TLB_SETS];

  logic [SET_BITS-1:0] lookSet, fillSet;
  logic [TAG_W-1:0]    lookTag, fillTag;
  logic [TLB_WAYS-1:0] lookMatch;

  assign lookSet   = lookupVpn[SET_BITS-1:0];
  assign lookTag   = lookupVpn[VPN_W-1:SET_BITS];
  assign fillSet   = fillVpn[SET_BITS-1:0];
  assign fillTag   = fillVpn[VPN_W-1:SET_BITS];
  assign fillValid = validMem[fillSet];

  for (genvar w = 0; w < TLB_WAYS; w++) begin : gCompare
    assign lookMatch[w] = validMem[lookSet][w] && (tagMem[lookSet][w] == lookTag);
    assign fillMatch[w] = validMem[fillSet][w] && (tagMem[fillSet][w] == fillTag);
  end

  always_comb begin
    lookupPpn = '0;
    for (int w = 0; w < TLB_WAYS; w++) begin
      if (lookMatch[w]) lookupPpn = lookupPpn | ppnMem[lookSet][w];
    end
  end
  assign lookupHit = |lookMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < TLB_SETS; s++) validMem[s] <= '0;
    end else if (strb.clrAll) begin
      for (int s = 0; s < TLB_SETS; s++) validMem[s] <= '0;
    end else if (strb.wrEn) begin
      validMem[fillSet] <= validMem[fillSet] | strb.wrWay;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      for (int w = 0; w < TLB_WAYS; w++) begin
        if (strb.wrWay[w]) begin
          tagMem[fillSet][w] <= fillTag;
          ppnMem[fillSet][w] <= fillPpn;
        end
      end
    end
  end

  // R6: no page number is ever stored twice in a set
  assert_single_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookMatch));

  // R7: nothing hits in the cycle after a flush
  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> !lookupHit);

  // R2: a miss drives a zero page number
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupHit |-> (lookupPpn == '0));
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int VPN_W = 8,
  parameter int PPN_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VPN_W-1:0] lookupVpn,
  output logic             lookupHit,
  output logic [PPN_W-1:0] lookupPpn,
  input  logic             fillEn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic             flush
);
  tlb_strobe_t         strb;
  logic [TLB_WAYS-1:0] fillMatch, fillValid;

  tlb_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .fillEn   (fillEn),
    .flush    (flush),
    .fillSet  (fillVpn[SET_BITS-1:0]),
    .fillMatch(fillMatch),
    .fillValid(fillValid),
    .strb     (strb)
  );

  tlb_store #(.VPN_W(VPN_W), .PPN_W(PPN_W)) uStore (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .fillVpn  (fillVpn),
    .fillPpn  (fillPpn),
    .lookupVpn(lookupVpn),
    .lookupHit(lookupHit),
    .lookupPpn(lookupPpn),
    .fillMatch(fillMatch),
    .fillValid(fillValid)
  );

  // R8: a fill is visible to a lookup of the same page in the next cycle
  assert_fill_visible_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !flush) |=> ((lookupVpn != $past(fillVpn)) ||
                            (lookupHit && lookupPpn == $past(fillPpn))));
endmodule

// File: tb/tlb_top_test.sv
`timescale 1ns/1ps
module tlb_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] lookupVpn = '0;
  logic       lookupHit;
  logic [5:0] lookupPpn;
  logic       fillEn = 1'b0;
  logic [7:0] fillVpn = '0;
  logic [5:0] fillPpn = '0;
  logic       flush = 1'b0;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural reference model
  int mTag [4][4];
  int mPpn [4][4];
  bit mVal [4][4];
  int mPtr [4];

  always #10 clk = ~clk;

  tlb_top uut (
    .clk(clk), .rstN(rstN), .lookupVpn(lookupVpn), .lookupHit(lookupHit),
    .lookupPpn(lookupPpn), .fillEn(fillEn), .fillVpn(fillVpn),
    .fillPpn(fillPpn), .flush(flush)
  );

  task automatic modelClear();
    for (int s = 0; s < 4; s++) begin
      mPtr[s] = 0;
      for (int w = 0; w < 4; w++) mVal[s][w] = 0;
    end
  endtask

  task automatic modelLook(input int vpn, output int hit, output int ppn);
    hit = 0; ppn = 0;
    for (int w = 0; w < 4; w++)
      if (mVal[vpn % 4][w] && mTag[vpn % 4][w] == vpn / 4) begin
        hit = 1; ppn = mPpn[vpn % 4][w];
      end
  endtask

  task automatic modelFill(input int vpn, input int ppn);
    int s, t, way;
    s = vpn % 4; t = vpn / 4; way = -1;
    for (int w = 0; w < 4; w++) if (mVal[s][w] && mTag[s][w] == t) way = w;
    if (way < 0) for (int w = 3; w >= 0; w--) if (!mVal[s][w]) way = w;
    if (way < 0) begin
      way = mPtr[s];
      mPtr[s] = (mPtr[s] + 1) % 4;
    end
    mVal[s][way] = 1; mTag[s][way] = t; mPpn[s][way] = ppn;
  endtask

  task automatic step(input int lv, input bit fe, input int fv, input int fp,
                      input bit fl, input string rq);
    int eh, ep;
    @(negedge clk);
    lookupVpn = 8'(lv); fillEn = fe; fillVpn = 8'(fv); fillPpn = 6'(fp); flush = fl;
    #2;
    modelLook(lv, eh, ep);
    vectors++;
    if (lookupHit !== eh[0] || lookupPpn !== 6'(ep)) begin
      fails++;
      $display("FAIL %s vpn=%02h actual hit=%0d ppn=%02h expected hit=%0d ppn=%02h",
               rq, lv, lookupHit, lookupPpn, eh, ep);
    end
    @(posedge clk);
    if (rstN) begin
      if (fl) modelClear();
      else if (fe) modelFill(fv, fp);
    end
  endtask

  task automatic look(input int lv, input string rq);
    step(lv, 0, 0, 0, 0, rq);
  endtask

  task automatic fill(input int fv, input int fp, input string rq);
    step(fv ^ 8'h80, 1, fv, fp, 0, rq);
  endtask

  initial begin
    modelClear();
    // R3: reset state, lookups miss while in and after reset
    step(8'h0F, 1, 8'h0F, 6'h0D, 0, "R3");
    rstN = 1'b1;
    for (int v = 0; v < 8; v++) look(v * 33, "R3");

    // R4: preload, each fill takes the lowest free way
    fill(8'h2B, 6'h34, "R4");
    fill(8'h0F, 6'h0D, "R4");
    fill(8'h24, 6'h0D, "R4");
    fill(8'h1C, 6'h02, "R4");
    fill(8'h0D, 6'h2D, "R4");
    // R9: worked translations
    look(8'h0F, "R9");
    look(8'h0A, "R9");
    look(8'h01, "R9");
    look(8'h2B, "R9");
    // R1: same tag in another set must miss
    look(8'h0C, "R1");
    look(8'h0E, "R1");
    // R6: refill in place
    fill(8'h0F, 6'h11, "R6");
    look(8'h0F, "R6");
    look(8'h2B, "R6");
    // R5: overflow set 2 and check victims in rotation
    for (int t = 0; t < 9; t++) begin
      fill(t * 4 + 2, 6'(t + 20), "R5");
      for (int k = 0; k < 9; k++) look(k * 4 + 2, "R5");
    end
    // R8: lookup during fill cycle then after
    step(8'h31, 1, 8'h31, 6'h3F, 0, "R8");
    look(8'h31, "R8");
    step(8'h31, 1, 8'h31, 6'h05, 0, "R8");
    look(8'h31, "R8");
    // R7: flush, then flush with simultaneous fill
    step(8'h31, 0, 0, 0, 1, "R7");
    for (int v = 0; v < 4; v++) look(v * 4 + 2, "R7");
    look(8'h31, "R7");
    step(8'h55, 1, 8'h55, 6'h12, 1, "R7");
    look(8'h55, "R7");
    for (int t = 0; t < 6; t++) begin
      fill(t * 4 + 1, 6'(t + 7), "R7");
      for (int k = 0; k < 6; k++) look(k * 4 + 1, "R7");
    end
    // R2: random traffic over a narrow range
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(99);
      step($urandom_range(47), r < 45, $urandom_range(47), $urandom_range(63),
           r == 99, "R2");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R2 actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule